// File: doc/BRIEF.md
# Conditional Write-Enable Gate with Dual Condition Registers

This block sits between a four-lane shader datapath and its temporary register file. For each issued instruction it turns the destination write mask into final per-lane write enables. When the instruction asks for a conditional write, each lane is gated by a comparison code tested against a stored condition flag set. The flag set comes from one of two condition registers, and a per-lane selector picks which of that register's lanes is tested.

The same instruction may also refresh the selected condition register from its own result. Each masked lane then records whether its result value was negative, zero or positive. The write enables are combinational in the issue cycle. A refresh lands on the next clock edge, so the next instruction sees it and the current one still tests the old flags.

Top module: `cc_write_gate`

## Requirements
- R1: After reset, every lane of both condition registers holds the equal flag set 3'b010, so each register output reads 12'h492.
- R2: With the test enable low, wr_en equals wmask while issue is high. While issue is low, wr_en is 4'b0000.
- R3: With the test enable high, comparison code 0 (never) gives wr_en 4'b0000 and code 7 (always) gives wr_en equal to wmask.
- R4: A flag set is stored as bit0 = less, bit1 = equal, bit2 = greater. Comparison code bit0 accepts less, bit1 accepts equal and bit2 accepts greater. A lane passes when any accepted flag is set: 1 = less, 2 = equal, 3 = less-or-equal, 4 = greater, 5 = not-equal, 6 = greater-or-equal.
- R5: Lane i tests the condition-register lane chosen by swz[2i+1:2i], where 0 selects x, 1 y, 2 z and 3 w. Register lane k occupies bits [3k+2:3k] of its output.
- R6: reg_sel = 0 tests and updates register 0 (cc0_q), and reg_sel = 1 tests and updates register 1 (cc1_q).
- R7: When issue and upd_en are both high, each lane with its wmask bit set loads a new flag set into lane i of the selected register at the next clock edge. Within the same cycle, the test still uses the old flags.
- R8: Lanes whose wmask bit is clear are left unchanged by an update. So is the register that reg_sel does not select. Nothing changes without both issue and upd_en.
- R9: The result lanes are W-bit two's-complement values, with lane i at result[16i+15:16i]. A lane stores less if its value is negative, equal if it is zero, and greater otherwise, including at the most negative and most positive values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction valid this cycle |
| wmask | input | 4 | Destination write mask, bit i for lane i (x = 0) |
| cond | input | 3 | Comparison code |
| swz | input | 8 | Per-lane condition lane selectors, 2 bits per lane |
| reg_sel | input | 1 | Condition register select |
| test_en | input | 1 | Apply the condition to the write |
| upd_en | input | 1 | Refresh the selected condition register from result |
| result | input | 64 | Four signed result lanes |
| wr_en | output | 4 | Final per-lane write enables |
| cc0_q | output | 12 | Condition register 0 state |
| cc1_q | output | 12 | Condition register 1 state |

## Verification
All eight comparison codes are applied against registers preloaded with a mix of less, equal and greater lanes. This separates a wrong code-bit to flag pairing from a wrong pass/fail polarity. Identity, reversed and broadcast selectors are used to show that each lane reads its own register lane rather than a fixed one. The update traffic does three things: it uses partial masks and the unselected register, it tests and refreshes in the same cycle, and it applies extreme signed values. These cases tell a lost mask gate, a read-after-write bypass and an unsigned compare apart.

// File: rtl/cc_write_gate.sv
module cc_write_gate #(
  parameter int W  = 16,
  parameter int NC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [NC-1:0]   wmask,
  input  logic [2:0]      cond,
  input  logic [NC*$clog2(NC)-1:0] swz,
  input  logic            reg_sel,
  input  logic            test_en,
  input  logic            upd_en,
  input  logic [NC*W-1:0] result,
  output logic [NC-1:0]   wr_en,
  output logic [NC*3-1:0] cc0_q,
  output logic [NC*3-1:0] cc1_q
);
  localparam int SW = $clog2(NC);
  localparam logic [2:0] EQ_FLAGS = 3'b010;

  logic [NC*3-1:0] cc0_r, cc1_r, fresh;
  logic [NC-1:0]   pass;

  for (genvar i = 0; i < NC; i++) begin : g_lane
    logic [SW-1:0]       pick;
    logic [2:0]          seen;
    logic signed [W-1:0] rv;

    assign pick = swz[i*SW +: SW];
    assign seen = reg_sel ? cc1_r[pick*3 +: 3] : cc0_r[pick*3 +: 3];
    assign pass[i] = |(cond & seen);
    assign wr_en[i] = issue & wmask[i] & (~test_en | pass[i]);

    assign rv = result[i*W +: W];
    assign fresh[i*3 +: 3] = (rv < 0) ? 3'b001 : ((rv == 0) ? 3'b010 : 3'b100);

    a_r4_flags_one_hot0: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cc0_q[i*3 +: 3]) == 1);
    a_r4_flags_one_hot1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cc1_q[i*3 +: 3]) == 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc0_r <= {NC{EQ_FLAGS}};
      cc1_r <= {NC{EQ_FLAGS}};
    end else if (issue && upd_en) begin
      for (int i = 0; i < NC; i++) begin
        if (wmask[i]) begin
          if (reg_sel) cc1_r[i*3 +: 3] <= fresh[i*3 +: 3];
          else         cc0_r[i*3 +: 3] <= fresh[i*3 +: 3];
        end
      end
    end
  end

  assign cc0_q = cc0_r;
  assign cc1_q = cc1_r;

  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> wr_en == '0);
  a_r2_untested_follows_mask: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !test_en |-> wr_en == wmask);
  a_r3_never_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    issue && test_en && cond == 3'd0 |-> wr_en == '0);
  a_r3_always_passes: assert property (@(posedge clk) disable iff (!rst_n)
    issue && test_en && cond == 3'd7 |-> wr_en == wmask);
  a_r8_no_update_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && upd_en) |=> $stable(cc0_q) && $stable(cc1_q));
  a_r8_other_reg_holds0: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |=> $stable(cc0_q));
  a_r8_other_reg_holds1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |=> $stable(cc1_q));
  a_r8_masked_lane_x_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wmask[0] |=> $stable(cc0_q[2:0]) && $stable(cc1_q[2:0]));
endmodule

// File: tb/sim_cc_write_gate.sv
module sim_cc_write_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  wmask = '0;
  logic [2:0]  cond = '0;
  logic [7:0]  swz = '0;
  logic        reg_sel = 1'b0;
  logic        test_en = 1'b0;
  logic        upd_en = 1'b0;
  logic [63:0] result = '0;
  logic [3:0]  wr_en;
  logic [11:0] cc0_q, cc1_q;

  always #2.5 clk = ~clk;

  cc_write_gate u0 (.clk(clk), .rst_n(rst_n), .issue(issue), .wmask(wmask), .cond(cond),
    .swz(swz), .reg_sel(reg_sel), .test_en(test_en), .upd_en(upd_en), .result(result),
    .wr_en(wr_en), .cc0_q(cc0_q), .cc1_q(cc1_q));

  typedef struct {
    logic [3:0]  we;
    logic [11:0] c0;
    logic [11:0] c1;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;
  logic [11:0] m_cc [2];

  function automatic logic [2:0] flags_of(logic signed [15:0] v);
    if (v < 0) return 3'b001;
    if (v == 0) return 3'b010;
    return 3'b100;
  endfunction

  task automatic op(input logic iss, input logic [3:0] wm, input logic [2:0] cd,
                    input logic [7:0] sz, input logic sel, input logic te, input logic ue,
                    input logic [63:0] res, input string tag);
    exp_t e;
    @(negedge clk);
    issue = iss; wmask = wm; cond = cd; swz = sz; reg_sel = sel;
    test_en = te; upd_en = ue; result = res;
    e.c0 = m_cc[0]; e.c1 = m_cc[1]; e.tag = tag;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] k;
      logic [2:0] f;
      k = sz[2*i +: 2];
      f = m_cc[sel][3*k +: 3];
      e.we[i] = iss && wm[i] && (!te || ((cd & f) != 3'b000));
    end
    q.push_back(e);
    if (iss && ue)
      for (int i = 0; i < 4; i++)
        if (wm[i]) m_cc[sel][3*i +: 3] = flags_of(res[16*i +: 16]);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (wr_en !== e.we || cc0_q !== e.c0 || cc1_q !== e.c1) begin
          failures++;
          $display("FAIL %s: actual we=%b cc0=%h cc1=%h expected we=%b cc0=%h cc1=%h",
                   e.tag, wr_en, cc0_q, cc1_q, e.we, e.c0, e.c1);
        end
      end
    end
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: actual hung expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [7:0] IDENT = 8'b11_10_01_00;
  localparam logic [7:0] REVRS = 8'b00_01_10_11;

  initial begin
    m_cc[0] = 12'h492; m_cc[1] = 12'h492;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    op(0, 4'h0, 3'd0, IDENT, 0, 0, 0, 64'h0, "R1 reset state");
    if (cc0_q !== 12'h492 || cc1_q !== 12'h492) begin
      failures++;
      $display("FAIL R1: actual cc0=%h cc1=%h expected 492", cc0_q, cc1_q);
    end
    checks++;
    op(1, 4'b1011, 3'd0, IDENT, 0, 0, 0, 64'h0, "R2 untested follows mask");
    op(0, 4'b1111, 3'd7, IDENT, 0, 1, 0, 64'h0, "R2 idle gives no write");
    op(1, 4'b1111, 3'd0, IDENT, 0, 1, 0, 64'h0, "R3 never code");
    op(1, 4'b0110, 3'd7, IDENT, 0, 1, 0, 64'h0, "R3 always code");
    op(1, 4'b1111, 3'd2, IDENT, 0, 1, 0, 64'h0, "R4 EQ on equal flags");
    op(1, 4'b1111, 3'd5, IDENT, 0, 1, 0, 64'h0, "R4 NE on equal flags");
    // R7: refresh reg 0 with -5, 0, 7, -1 while testing GT on old equal flags
    op(1, 4'b1111, 3'd4, IDENT, 0, 1, 1, {16'hFFFF, 16'd7, 16'd0, 16'hFFFB}, "R7 old flags in update cycle");
    for (int c = 0; c < 8; c++) begin
      op(1, 4'b1111, c[2:0], IDENT, 0, 1, 0, 64'h0, "R4 code sweep identity");
      op(1, 4'b1111, c[2:0], REVRS, 0, 1, 0, 64'h0, "R5 reversed selector");
    end
    op(1, 4'b1111, 3'd4, 8'b10_10_10_10, 0, 1, 0, 64'h0, "R5 broadcast z");
    op(1, 4'b1111, 3'd1, 8'b00_00_00_00, 0, 1, 0, 64'h0, "R5 broadcast x");
    op(1, 4'b1111, 3'd2, IDENT, 1, 1, 0, 64'h0, "R6 reg 1 still equal");
    op(1, 4'b0101, 3'd0, IDENT, 1, 0, 1, {16'd3, 16'd9, 16'd3, 16'hFFF0}, "R8 partial mask update");
    op(0, 4'b1111, 3'd0, IDENT, 1, 0, 1, {16'd0, 16'd0, 16'd0, 16'd0}, "R8 no issue no update");
    op(1, 4'b1111, 3'd1, IDENT, 1, 1, 0, 64'h0, "R6 test reg 1 LT");
    op(1, 4'b1111, 3'd6, IDENT, 0, 1, 0, 64'h0, "R6 test reg 0 GE");
    op(1, 4'b1111, 3'd0, IDENT, 0, 0, 1, {16'h7FFF, 16'h8000, 16'h0001, 16'h0000}, "R9 extreme values");
    op(1, 4'b1111, 3'd3, IDENT, 0, 1, 0, 64'h0, "R9 LE after extremes");
    op(1, 4'b1111, 3'd4, REVRS, 0, 1, 0, 64'h0, "R9 GT reversed after extremes");
    op(0, 4'h0, 3'd0, IDENT, 0, 0, 0, 64'h0, "R8 final state");
    @(negedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule